// File: doc/BRIEF.md
# Dual-Channel DAC Command Port

This block is the digital front end of a two-channel 10-bit voltage DAC. A host drives a three-wire serial link: an active-low select, a serial clock, and a data line. Each select-low period carries one 16-bit command word, most significant bit first. The data line is sampled on each falling serial-clock edge. The four top bits of the word give the register target and the speed and power-down modes. The lower twelve bits carry either a DAC code or a reference choice.

The register map is double-buffered. A code can be parked in a holding buffer. A later channel-A write then copies that buffered code into channel B in the same cycle, so both outputs move together. The serial pins are brought into the system clock domain through two-flop synchronisers, and edges are found there. The block then drives two output codes, the fast/slow and power-down levels, and a reference-source code to the analog core. It also gives a one-cycle strobe each time a frame is applied.

Top module: `dual_dac_cmd_port`

## Requirements
- R1: While reset is low, at the next clock edge every output goes to zero: both codes, buffer, fast, power-down, reference code and strobe.
- R2: With select low, bits are taken on falling serial-clock edges, first bit received = word bit 15. The word is applied once the 16th bit arrives, and the outputs show it within 4 system clocks of that edge. Any further bits in the same select-low period are ignored.
- R3: Target code {bit15, bit12} = 00 loads the 10-bit code into both channel B and the holding buffer. Channel A is left unchanged.
- R4: Target code 01 loads the holding buffer only. Both channel outputs stay unchanged.
- R5: Target code 10 loads channel A with the new code. In the same cycle it loads channel B with the buffer contents held before that frame.
- R6: Target code 11 sets the reference output from word bits 1:0. 01 gives code 01 (low internal). 10 gives code 10 (high internal). 00 and 11 both give 00 (external). Bits 11:2 and both channel codes are left unchanged.
- R7: For code writes, the code is word bits 11:2. Bits 1:0 have no effect.
- R8: Every applied frame, whatever its target, sets the fast output to bit 14 and the power-down output to bit 13.
- R9: If select rises before any bit has been clocked in, nothing changes and no strobe is given.
- R10: If select rises after 1 to 15 bits, the bits received are applied as the low bits of a word whose upper bits are zero.
- R11: A word sent as two 8-bit bursts, with select held low and a pause between them, gives the same result as one 16-bit burst.
- R12: The strobe is high for exactly one clock per applied frame, in the cycle the outputs take the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| code_a_o | output | 10 | Channel A code to the analog core |
| code_b_o | output | 10 | Channel B code to the analog core |
| fast_o | output | 1 | 1 = fast settling mode, 0 = slow |
| pdown_o | output | 1 | 1 = power down |
| ref_sel_o | output | 2 | 00 external, 01 low internal, 10 high internal |
| upd_o | output | 1 | One-cycle strobe when a frame is applied |

## Verification
A pin change passes through two synchroniser flops and one edge-history flop before the frame logic acts on it. The applied word is registered once more before the latches and the strobe change. The result of a completing sclk fall or select rise is therefore due about 4 system clocks later. The bench waits well past that (12 clocks) after select rises, and samples on the falling clock edge. It counts strobe pulses over the whole frame, so a missing strobe or an extra one is caught. It then checks the codes, the modes and the reference code against hand-computed values.

// File: rtl/dacif_pkg.sv
// Package: shared widths and encodings for the dual DAC command port.
// Assumes a 16-bit command word with a 4-bit header and a 10-bit code field.
package dacif_pkg;
    localparam int WORD_W  = 16;
    localparam int CODE_W  = 10;
    localparam int HDR_W   = 4;
    localparam int CODE_LSB = WORD_W - HDR_W - CODE_W;

    // Register target taken from header bits {15,12}
    typedef enum logic [1:0] {
        TGT_B_AND_BUF = 2'b00,
        TGT_BUF_ONLY  = 2'b01,
        TGT_A_XFER_B  = 2'b10,
        TGT_CTRL      = 2'b11
    } tgt_e;

    // Reference source code driven to the analog core
    typedef enum logic [1:0] {
        REFSRC_EXT = 2'b00,
        REFSRC_LO  = 2'b01,
        REFSRC_HI  = 2'b10
    } refsrc_e;
endpackage

// File: rtl/dacif_sync.sv
// Module: dacif_sync
// Two-flop synchroniser for a bundle of asynchronous pins.
// Assumes each bit is independent; reset value set per bit by RST_VAL.
module dacif_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1_q, s2_q;
            // Two register stages to settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q <= RST_VAL[g];
                    s2_q <= RST_VAL[g];
                end else begin
                    s1_q <= d_i[g];
                    s2_q <= s1_q;
                end
            end
            assign q_o[g] = s2_q;
        end
    endgenerate
endmodule

// File: rtl/dacif_shifter.sv
// Module: dacif_shifter
// Detects select and serial-clock edges on synchronised pins.
// Shifts the data in MSB first and emits a one-cycle commit with the word.
// A word is committed after WORD_W bits. It is also committed on select
// rise if at least one bit arrived. Bits after a full word are dropped.
// Assumes the pins are already synchronised to clk.
module dacif_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic              cs_q, sclk_q;
    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              spent_q;

    logic cs_fall, cs_rise, bit_tick;
    logic [WORD_W-1:0] sh_next;

    // Edge history of the synchronised pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n_s;
            sclk_q <= sclk_s;
        end
    end

    assign cs_fall  = cs_q & ~cs_n_s;
    assign cs_rise  = ~cs_q & cs_n_s;
    assign bit_tick = sclk_q & ~sclk_s & ~cs_n_s;
    assign sh_next  = {sh_q[WORD_W-2:0], sdi_s};

    // Frame assembly and commit generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            spent_q  <= 1'b1;
            commit_o <= 1'b0;
            word_o   <= '0;
        end else begin
            commit_o <= 1'b0;
            if (cs_fall) begin
                sh_q    <= '0;
                cnt_q   <= '0;
                spent_q <= 1'b0;
            end else if (cs_rise) begin
                if (!spent_q && cnt_q != '0) begin
                    commit_o <= 1'b1;
                    word_o   <= sh_q;
                end
                spent_q <= 1'b1;
                cnt_q   <= '0;
            end else if (bit_tick && !spent_q) begin
                sh_q <= sh_next;
                if (cnt_q == LAST) begin
                    commit_o <= 1'b1;
                    word_o   <= sh_next;
                    spent_q  <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dacif_regmap.sv
// Module: dacif_regmap
// Decodes a committed command word into the channel latches, the holding
// buffer and the control register. It also raises an update strobe.
// Assumes commit_i is a single-cycle pulse.
module dacif_regmap
    import dacif_pkg::*;
#(
    parameter int WORD_W = dacif_pkg::WORD_W,
    parameter int CODE_W = dacif_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic [CODE_W-1:0] buf_o,
    output logic              fast_o,
    output logic              pdown_o,
    output logic [1:0]        ref_o,
    output logic              upd_o
);
    localparam int LSB = WORD_W - 4 - CODE_W;

    tgt_e              tgt;
    logic [CODE_W-1:0] code;
    refsrc_e           ref_dec;

    assign tgt  = tgt_e'({word_i[WORD_W-1], word_i[WORD_W-4]});
    assign code = word_i[LSB +: CODE_W];

    // Reference field decode; both unused patterns fall back to external
    always_comb begin
        case (word_i[1:0])
            2'b01:   ref_dec = REFSRC_LO;
            2'b10:   ref_dec = REFSRC_HI;
            default: ref_dec = REFSRC_EXT;
        endcase
    end

    // Latch update on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_a_o <= '0;
            code_b_o <= '0;
            buf_o    <= '0;
            fast_o   <= 1'b0;
            pdown_o  <= 1'b0;
            ref_o    <= REFSRC_EXT;
            upd_o    <= 1'b0;
        end else begin
            upd_o <= commit_i;
            if (commit_i) begin
                fast_o  <= word_i[WORD_W-2];
                pdown_o <= word_i[WORD_W-3];
                case (tgt)
                    TGT_B_AND_BUF: begin
                        code_b_o <= code;
                        buf_o    <= code;
                    end
                    TGT_BUF_ONLY: buf_o <= code;
                    TGT_A_XFER_B: begin
                        code_a_o <= code;
                        code_b_o <= buf_o;
                    end
                    default: ref_o <= ref_dec;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_dac_cmd_port.sv
// Module: dual_dac_cmd_port (top)
// Serial command front end of a two-channel DAC. It synchronises the three
// serial pins, assembles command words and applies them to the register map.
// Assumes clk is several times faster than the serial clock. Each serial
// level must hold for at least three clk cycles.
module dual_dac_cmd_port
    import dacif_pkg::*;
#(
    parameter int WORD_W = dacif_pkg::WORD_W,
    parameter int CODE_W = dacif_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              fast_o,
    output logic              pdown_o,
    output logic [1:0]        ref_sel_o,
    output logic              upd_o
);
    logic [2:0]        pins_s;
    logic              commit;
    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] buf_code;

    dacif_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sclk_i, sdi_i}),
        .q_o   (pins_s)
    );

    dacif_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .commit_o (commit),
        .word_o   (word)
    );

    dacif_regmap #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .code_a_o (code_a_o),
        .code_b_o (code_b_o),
        .buf_o    (buf_code),
        .fast_o   (fast_o),
        .pdown_o  (pdown_o),
        .ref_o    (ref_sel_o),
        .upd_o    (upd_o)
    );
endmodule

// File: rtl/dacif_chk.sv
// Module: dacif_chk
// Checker for dual_dac_cmd_port. It watches the commit word and the
// outputs across cycles. It is attached by the bind statement below.
module dacif_chk #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic [WORD_W-1:0] word,
    input logic [CODE_W-1:0] buf_code,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic              fast,
    input logic              pdown,
    input logic [1:0]        ref_sel,
    input logic              upd
);
    logic [1:0] tgt;
    assign tgt = {word[WORD_W-1], word[WORD_W-4]};

    AST_UPD_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> upd) else $error("strobe missing"); // R12
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd) else $error("strobe too long"); // R12
    AST_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(code_a)) else $error("A moved without strobe"); // R9
    AST_B_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tgt == 2'b10) |=> code_b == $past(buf_code)) else $error("B transfer"); // R5
    AST_CTRL_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tgt == 2'b11) |=> ($stable(code_a) && $stable(code_b))) else $error("ctrl touched codes"); // R6
    AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (fast == $past(word[WORD_W-2]) && pdown == $past(word[WORD_W-3]))) else $error("mode bits"); // R8
    AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sel != 2'b11) else $error("reference code"); // R6
endmodule

bind dual_dac_cmd_port dacif_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .word     (word),
    .buf_code (buf_code),
    .code_a   (code_a_o),
    .code_b   (code_b_o),
    .fast     (fast_o),
    .pdown    (pdown_o),
    .ref_sel  (ref_sel_o),
    .upd      (upd_o)
);

// File: tb/tb_dual_dac_cmd_port.sv
module tb_dual_dac_cmd_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int NVEC       = 10;

    // {word[15:0], nbits[4:0], exp_a[9:0], exp_b[9:0], fast, pdown, ref[1:0]}
    localparam logic [44:0] VEC [NVEC] = '{
        {16'h4557, 5'd16, 10'h000, 10'h155, 1'b1, 1'b0, 2'd0}, // R3 R7
        {16'h1AA8, 5'd16, 10'h000, 10'h155, 1'b0, 1'b0, 2'd0}, // R4
        {16'hCFFC, 5'd16, 10'h3FF, 10'h2AA, 1'b1, 1'b0, 2'd0}, // R5
        {16'h9FF1, 5'd16, 10'h3FF, 10'h2AA, 1'b0, 1'b0, 2'd1}, // R6
        {16'hB002, 5'd16, 10'h3FF, 10'h2AA, 1'b0, 1'b1, 2'd2}, // R6 R8
        {16'hD003, 5'd16, 10'h3FF, 10'h2AA, 1'b1, 1'b0, 2'd0}, // R6
        {16'h8004, 5'd16, 10'h001, 10'h2AA, 1'b0, 1'b0, 2'd0}, // R5
        {16'h0000, 5'd0,  10'h001, 10'h2AA, 1'b0, 1'b0, 2'd0}, // R9
        {16'h03F0, 5'd12, 10'h001, 10'h0FC, 1'b0, 1'b0, 2'd0}, // R10
        {16'h8800, 5'd16, 10'h200, 10'h0FC, 1'b0, 1'b0, 2'd0}  // R5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic [9:0] code_a, code_b;
    logic fast, pdown, upd;
    logic [1:0] ref_sel;
    int tests = 0, fails = 0, upd_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dac_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .code_a_o(code_a), .code_b_o(code_b), .fast_o(fast), .pdown_o(pdown),
        .ref_sel_o(ref_sel), .upd_o(upd)
    );

    // Strobe pulse counter, sampled away from the active edge
    always @(negedge clk) if (upd) upd_cnt++;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_clk(HALF_BIT);
        sclk = 1'b0;
        wait_clk(HALF_BIT);
        sclk = 1'b1;
    endtask

    // Send the low n bits of w, highest first, in one select-low period
    task automatic frame(input logic [31:0] w, input int n);
        cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
        wait_clk(HALF_BIT);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic check_all(input string tag, input logic [9:0] a, input logic [9:0] b,
                             input logic f, input logic p, input logic [1:0] r);
        check({tag, " code_a"}, 32'(code_a), 32'(a));
        check({tag, " code_b"}, 32'(code_b), 32'(b));
        check({tag, " fast"}, 32'(fast), 32'(f));
        check({tag, " pdown"}, 32'(pdown), 32'(p));
        check({tag, " ref"}, 32'(ref_sel), 32'(r));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_clk(4);
        check_all("R1 reset", 10'h0, 10'h0, 1'b0, 1'b0, 2'd0);
        check("R1 reset upd", 32'(upd), 32'd0);
        rst_n = 1'b1;
        wait_clk(4);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
        for (int k = 0; k < NVEC; k++) begin
            logic [44:0] v;
            v = VEC[k];
            upd_cnt = 0;
            frame(32'(v[44:29]), int'(v[28:24]));
            check_all($sformatf("R2 vec%0d", k), v[23:14], v[13:4], v[3], v[2], v[1:0]);
            check($sformatf("R12 vec%0d strobes", k), 32'(upd_cnt), (v[28:24] != 0) ? 32'd1 : 32'd0);
        end

        // R2: bits after the 16th are dropped (sel 00, code 0x100)
        upd_cnt = 0;
        frame({16'h0400, 4'hF}, 20);
        check_all("R2 extra bits", 10'h200, 10'h100, 1'b0, 1'b0, 2'd0);
        check("R2 extra bits strobes", 32'(upd_cnt), 32'd1);

        // R11: two bytes with a pause, select held low (sel 00, fast, code 0x300)
        upd_cnt = 0;
        cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = 15; i >= 8; i--) send_bit(logic'((16'h4C00 >> i) & 1));
        wait_clk(30);
        for (int i = 7; i >= 0; i--) send_bit(logic'((16'h4C00 >> i) & 1));
        wait_clk(HALF_BIT);
        cs_n = 1'b1;
        wait_clk(12);
        check_all("R11 bytes", 10'h200, 10'h300, 1'b1, 1'b0, 2'd0);
        check("R11 strobes", 32'(upd_cnt), 32'd1);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        wait_clk(3);
        check_all("R1 mid reset", 10'h0, 10'h0, 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;
        wait_clk(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule